// File: doc/BRIEF.md
# Event Counter Bank with Dual Match

This block holds a small bank of event counters, three by default. Each counter advances only when its own single-bit control inputs tell it to. Each counter has four controls: a synchronous clear, an event strobe, a qualifier and a direction/data bit. It also has two static mode inputs. One mode input chooses between arithmetic counting and shift-register operation. The other makes a qualified event copy a preset into the count instead of stepping it.

Every counter owns three configuration words: a preset, a first match value and a second match value. All three counters share a single word-addressed write port and a single address map. The live counts are driven out in parallel. One count at a time can also be read back through a select input.

Each counter has two match flags. A flag pulses for one cycle when its count becomes equal to the corresponding match word. The flags are meant for a downstream controller, which is not part of this block.

Top module: `evc_bank`

## Requirements
- R1: While `rst_n` is low, every count, preset and match word clears to zero on the clock edge, and all match flags are low.
- R2: While a counter's `ctl_clear` bit is high, its count becomes zero at the next edge, whatever its other controls and modes are.
- R3: A qualified event is a cycle with both `ctl_event` and `ctl_qual` high. In add mode (`mode_shift` = 0, `mode_load` = 0), a qualified event adds one when `ctl_dir` = 1 and subtracts one when `ctl_dir` = 0, wrapping modulo 2^32. Without a qualified event the count holds.
- R4: In shift mode (`mode_shift` = 1, `mode_load` = 0), a qualified event shifts the count left by one bit and puts `ctl_dir` into bit 0.
- R5: When `mode_load` = 1, a qualified event copies the counter's preset into the count, whatever `mode_shift` is.
- R6: A write with `cfg_we` = 1 decodes `cfg_addr[3:2]` as the field (0 preset, 1 first match, 2 second match) and `cfg_addr[1:0]` as the counter index. Field 3, or an index of `NUM_CTR` or above, changes nothing.
- R7: `match1[i]` is high in a cycle exactly when count i equals its first match word and did not equal it in the previous cycle. `match2[i]` follows the same rule for the second match word. A flag is never high for two cycles in a row.
- R8: `rd_data` shows the count of the counter selected by `rd_sel`. It shows zero for a select of `NUM_CTR` or above.
- R9: Each counter responds only to its own controls, modes and configuration words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address: field in [3:2], counter index in [1:0] |
| cfg_wdata | input | CNT_W | Configuration write data |
| mode_shift | input | NUM_CTR | Per counter: 1 selects shift operation, 0 add counting |
| mode_load | input | NUM_CTR | Per counter: 1 makes a qualified event load the preset |
| ctl_clear | input | NUM_CTR | Per counter synchronous clear of the count |
| ctl_event | input | NUM_CTR | Per counter event strobe |
| ctl_qual | input | NUM_CTR | Per counter event qualifier |
| ctl_dir | input | NUM_CTR | Per counter: count direction in add mode, shifted-in bit in shift mode |
| rd_sel | input | 2 | Counter index for read-back |
| rd_data | output | CNT_W | Count of the selected counter |
| count_flat | output | NUM_CTR*CNT_W | All live counts, counter i in bits [i*CNT_W +: CNT_W] |
| match1 | output | NUM_CTR | First-match pulses |
| match2 | output | NUM_CTR | Second-match pulses |

## Verification
The hardest situations to reach from the ports are the match pulses that arrive by an unusual route. One is a count that wraps from zero down to all ones onto a match word. Another is a clear that drops a large preloaded count onto a match word of zero. A third is a configuration write that moves a match word away from, or onto, a count that is standing still.

Directed sequences build each of these on purpose. A preset is loaded and then cleared while its match word sits at zero. A counter is decremented from zero. Match words are rewritten while their count is idle.

A long random phase follows. It keeps the match words small and the clear rare, so add-mode counts wander around zero. Along the way they cross matches in both directions, and the mode inputs flip every few hundred cycles.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // Configuration address layout: field code in the upper two bits,
  // counter index in the lower two.
  localparam int EVC_ADDR_W = 4;
  localparam int EVC_IDX_W  = 2;

  typedef enum logic [1:0] {
    FLD_PRESET = 2'd0,
    FLD_MATCH1 = 2'd1,
    FLD_MATCH2 = 2'd2,
    FLD_NONE   = 2'd3
  } evc_field_e;

  typedef struct packed {
    logic clr;
    logic evt;
    logic qual;
    logic dir;
  } evc_ctl_t;

  function automatic evc_field_e field_of(input logic [EVC_ADDR_W-1:0] addr);
    return evc_field_e'(addr[EVC_ADDR_W-1:EVC_IDX_W]);
  endfunction

  function automatic logic [EVC_IDX_W-1:0] index_of(input logic [EVC_ADDR_W-1:0] addr);
    return addr[EVC_IDX_W-1:0];
  endfunction

endpackage

// File: rtl/evc_cfg_regs.sv
module evc_cfg_regs
  import evc_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [EVC_ADDR_W-1:0]    cfg_addr,
  input  logic [CNT_W-1:0]         cfg_wdata,
  output logic [NUM_CTR*CNT_W-1:0] preset_flat,
  output logic [NUM_CTR*CNT_W-1:0] m1_flat,
  output logic [NUM_CTR*CNT_W-1:0] m2_flat
);

  evc_field_e           wr_field;
  logic [EVC_IDX_W-1:0] wr_idx;

  assign wr_field = field_of(cfg_addr);
  assign wr_idx   = index_of(cfg_addr);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    logic            sel_here;
    logic            we_preset;
    logic            we_m1;
    logic            we_m2;
    logic [CNT_W-1:0] preset_q;
    logic [CNT_W-1:0] m1_q;
    logic [CNT_W-1:0] m2_q;

    assign sel_here  = cfg_we && (wr_idx == EVC_IDX_W'(i));
    assign we_preset = sel_here && (wr_field == FLD_PRESET);
    assign we_m1     = sel_here && (wr_field == FLD_MATCH1);
    assign we_m2     = sel_here && (wr_field == FLD_MATCH2);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        preset_q <= '0;
        m1_q     <= '0;
        m2_q     <= '0;
      end else begin
        if (we_preset) preset_q <= cfg_wdata;
        if (we_m1)     m1_q     <= cfg_wdata;
        if (we_m2)     m2_q     <= cfg_wdata;
      end
    end

    assign preset_flat[i*CNT_W +: CNT_W] = preset_q;
    assign m1_flat[i*CNT_W +: CNT_W]     = m1_q;
    assign m2_flat[i*CNT_W +: CNT_W]     = m2_q;
  end

endmodule

// File: rtl/evc_core.sv
module evc_core
  import evc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  evc_ctl_t         ctl,
  input  logic             shift_mode,
  input  logic             load_mode,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             qual_evt
);

  function automatic logic [CNT_W-1:0] add_step(input logic [CNT_W-1:0] v,
                                                input logic up);
    return up ? v + CNT_W'(1) : v - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] shift_step(input logic [CNT_W-1:0] v,
                                                  input logic bit_in);
    return {v[CNT_W-2:0], bit_in};
  endfunction

  logic [CNT_W-1:0] count_nxt;

  assign qual_evt = ctl.evt && ctl.qual;

  always_comb begin
    count_nxt = count;
    if (ctl.clr) begin
      count_nxt = '0;
    end else if (qual_evt) begin
      if (load_mode)       count_nxt = preset;
      else if (shift_mode) count_nxt = shift_step(count, ctl.dir);
      else                 count_nxt = add_step(count, ctl.dir);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

endmodule

// File: rtl/evc_match.sv
module evc_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] target,
  output logic             equal,
  output logic             pulse
);

  logic equal_q;

  assign equal = (count == target);

  // Held high through reset: count and target both clear to zero,
  // so the equality that exists at release is not a new one.
  always_ff @(posedge clk) begin
    if (!rst_n) equal_q <= 1'b1;
    else        equal_q <= equal;
  end

  assign pulse = equal && !equal_q;

endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [EVC_ADDR_W-1:0]    cfg_addr,
  input  logic [CNT_W-1:0]         cfg_wdata,
  input  logic [NUM_CTR-1:0]       mode_shift,
  input  logic [NUM_CTR-1:0]       mode_load,
  input  logic [NUM_CTR-1:0]       ctl_clear,
  input  logic [NUM_CTR-1:0]       ctl_event,
  input  logic [NUM_CTR-1:0]       ctl_qual,
  input  logic [NUM_CTR-1:0]       ctl_dir,
  input  logic [EVC_IDX_W-1:0]     rd_sel,
  output logic [CNT_W-1:0]         rd_data,
  output logic [NUM_CTR*CNT_W-1:0] count_flat,
  output logic [NUM_CTR-1:0]       match1,
  output logic [NUM_CTR-1:0]       match2
);

  logic [NUM_CTR*CNT_W-1:0] preset_flat;
  logic [NUM_CTR*CNT_W-1:0] m1_flat;
  logic [NUM_CTR*CNT_W-1:0] m2_flat;
  logic [NUM_CTR-1:0]       qual_evt;
  logic [NUM_CTR-1:0]       eq1;
  logic [NUM_CTR-1:0]       eq2;

  evc_cfg_regs #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .preset_flat (preset_flat),
    .m1_flat     (m1_flat),
    .m2_flat     (m2_flat)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    evc_ctl_t         ctl;
    logic [CNT_W-1:0] cnt;

    assign ctl = '{clr: ctl_clear[i], evt: ctl_event[i],
                   qual: ctl_qual[i], dir: ctl_dir[i]};

    evc_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .shift_mode (mode_shift[i]),
      .load_mode  (mode_load[i]),
      .preset     (preset_flat[i*CNT_W +: CNT_W]),
      .count      (cnt),
      .qual_evt   (qual_evt[i])
    );

    evc_match #(.CNT_W(CNT_W)) u_m1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .count  (cnt),
      .target (m1_flat[i*CNT_W +: CNT_W]),
      .equal  (eq1[i]),
      .pulse  (match1[i])
    );

    evc_match #(.CNT_W(CNT_W)) u_m2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .count  (cnt),
      .target (m2_flat[i*CNT_W +: CNT_W]),
      .equal  (eq2[i]),
      .pulse  (match2[i])
    );

    assign count_flat[i*CNT_W +: CNT_W] = cnt;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (rd_sel == EVC_IDX_W'(i)) rd_data = count_flat[i*CNT_W +: CNT_W];
    end
  end

endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk
  import evc_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CTR-1:0]       mode_shift,
  input logic [NUM_CTR-1:0]       mode_load,
  input logic [NUM_CTR-1:0]       ctl_clear,
  input logic [NUM_CTR-1:0]       ctl_event,
  input logic [NUM_CTR-1:0]       ctl_qual,
  input logic [NUM_CTR-1:0]       ctl_dir,
  input logic [EVC_IDX_W-1:0]     rd_sel,
  input logic [CNT_W-1:0]         rd_data,
  input logic [NUM_CTR*CNT_W-1:0] count_flat,
  input logic [NUM_CTR*CNT_W-1:0] preset_flat,
  input logic [NUM_CTR*CNT_W-1:0] m1_flat,
  input logic [NUM_CTR*CNT_W-1:0] m2_flat,
  input logic [NUM_CTR-1:0]       match1,
  input logic [NUM_CTR-1:0]       match2
);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    logic q;
    assign q = ctl_event[i] && ctl_qual[i];

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_clear[i] |=> count_flat[i*CNT_W +: CNT_W] == '0);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_clear[i] && !q) |=> $stable(count_flat[i*CNT_W +: CNT_W]));

    a_r3_up: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_clear[i] && q && !mode_load[i] && !mode_shift[i] && ctl_dir[i])
      |=> count_flat[i*CNT_W +: CNT_W] == $past(count_flat[i*CNT_W +: CNT_W]) + CNT_W'(1));

    a_r3_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_clear[i] && q && !mode_load[i] && !mode_shift[i] && !ctl_dir[i])
      |=> count_flat[i*CNT_W +: CNT_W] == $past(count_flat[i*CNT_W +: CNT_W]) - CNT_W'(1));

    a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_clear[i] && q && !mode_load[i] && mode_shift[i])
      |=> count_flat[i*CNT_W +: CNT_W] ==
          {$past(count_flat[i*CNT_W +: CNT_W-1]), $past(ctl_dir[i])});

    a_r5_preset: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_clear[i] && q && mode_load[i])
      |=> count_flat[i*CNT_W +: CNT_W] == $past(preset_flat[i*CNT_W +: CNT_W]));

    a_r7_m1_equal: assert property (@(posedge clk) disable iff (!rst_n)
      match1[i] |-> count_flat[i*CNT_W +: CNT_W] == m1_flat[i*CNT_W +: CNT_W]);

    a_r7_m2_equal: assert property (@(posedge clk) disable iff (!rst_n)
      match2[i] |-> count_flat[i*CNT_W +: CNT_W] == m2_flat[i*CNT_W +: CNT_W]);

    a_r7_m1_single: assert property (@(posedge clk) disable iff (!rst_n)
      match1[i] |=> !match1[i]);

    a_r7_m2_single: assert property (@(posedge clk) disable iff (!rst_n)
      match2[i] |=> !match2[i]);
  end

  a_r8_rd_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_sel) >= NUM_CTR) |-> rd_data == '0);

endmodule

bind evc_bank evc_bank_chk #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_shift  (mode_shift),
  .mode_load   (mode_load),
  .ctl_clear   (ctl_clear),
  .ctl_event   (ctl_event),
  .ctl_qual    (ctl_qual),
  .ctl_dir     (ctl_dir),
  .rd_sel      (rd_sel),
  .rd_data     (rd_data),
  .count_flat  (count_flat),
  .preset_flat (preset_flat),
  .m1_flat     (m1_flat),
  .m2_flat     (m2_flat),
  .match1      (match1),
  .match2      (match2)
);

// File: tb/tb_evc_bank.sv
`timescale 1ns/1ps
module tb_evc_bank;

  localparam int N = 3;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [3:0]     cfg_addr = '0;
  logic [W-1:0]   cfg_wdata = '0;
  logic [N-1:0]   mode_shift = '0, mode_load = '0;
  logic [N-1:0]   ctl_clear = '0, ctl_event = '0, ctl_qual = '0, ctl_dir = '0;
  logic [1:0]     rd_sel = '0;
  logic [W-1:0]   rd_data;
  logic [N*W-1:0] count_flat;
  logic [N-1:0]   match1, match2;

  evc_bank #(.NUM_CTR(N), .CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mode_shift(mode_shift), .mode_load(mode_load),
    .ctl_clear(ctl_clear), .ctl_event(ctl_event), .ctl_qual(ctl_qual),
    .ctl_dir(ctl_dir), .rd_sel(rd_sel), .rd_data(rd_data),
    .count_flat(count_flat), .match1(match1), .match2(match2)
  );

  always #5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  // Reference state, advanced behaviourally at each rising edge.
  logic [W-1:0] r_cnt [N];
  logic [W-1:0] r_pre [N];
  logic [W-1:0] r_m1  [N];
  logic [W-1:0] r_m2  [N];
  bit           r_was1 [N];
  bit           r_was2 [N];

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        r_cnt[i] = 0; r_pre[i] = 0; r_m1[i] = 0; r_m2[i] = 0;
        r_was1[i] = 1; r_was2[i] = 1;
      end else begin
        r_was1[i] = (r_cnt[i] == r_m1[i]);
        r_was2[i] = (r_cnt[i] == r_m2[i]);
        if (ctl_clear[i]) r_cnt[i] = 0;
        else if (ctl_event[i] && ctl_qual[i]) begin
          if (mode_load[i])       r_cnt[i] = r_pre[i];
          else if (mode_shift[i]) r_cnt[i] = (r_cnt[i] << 1) | W'(ctl_dir[i]);
          else if (ctl_dir[i])    r_cnt[i] = r_cnt[i] + 1;
          else                    r_cnt[i] = r_cnt[i] - 1;
        end
      end
    end
    if (rst_n && cfg_we && (cfg_addr % 4) < N) begin
      case (cfg_addr / 4)
        0: r_pre[cfg_addr % 4] = cfg_wdata;
        1: r_m1[cfg_addr % 4]  = cfg_wdata;
        2: r_m2[cfg_addr % 4]  = cfg_wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(input string t, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int i = 0; i < N; i++) begin
        chk(tag, $sformatf("ctr%0d count", i), count_flat[i*W +: W], r_cnt[i]);
        chk("R7", $sformatf("ctr%0d match1", i), W'(match1[i]),
            W'((r_cnt[i] == r_m1[i]) && !r_was1[i]));
        chk("R7", $sformatf("ctr%0d match2", i), W'(match2[i]),
            W'((r_cnt[i] == r_m2[i]) && !r_was2[i]));
      end
      chk("R8", "rd_data", rd_data, (rd_sel < N) ? r_cnt[rd_sel] : '0);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    cfg_we = 0; ctl_clear = 0; ctl_event = 0; ctl_qual = 0; ctl_dir = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 0;
  endtask

  task automatic drive(input int i, input bit c, input bit e, input bit q, input bit d);
    ctl_clear[i] = c; ctl_event[i] = e; ctl_qual[i] = q; ctl_dir[i] = d;
  endtask

  function automatic logic [W-1:0] cnt_of(input int i);
    return count_flat[i*W +: W];
  endfunction

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset
    rst_n = 0;
    @(posedge clk);
    #1 cmp_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1;
    step();
    chk("R1", "counts after reset", count_flat[W-1:0] | count_flat[2*W-1:W] | count_flat[3*W-1:2*W], '0);
    chk("R1", "flags after reset", W'({match1, match2}), '0);

    // R6: address map, with ignored field 3 and index 3
    tag = "R6";
    wr(4'h0, 32'hA5A5_0001);
    wr(4'h1, 32'h0000_0011);
    wr(4'h3, 32'hDEAD_0000);
    wr(4'hC, 32'h0000_0007);
    wr(4'hE, 32'h0000_0009);
    wr(4'h6, 32'd2);
    wr(4'hA, 32'd5);

    // R5: preset load on counters 0 and 1
    tag = "R5";
    mode_load = 3'b011;
    drive(0, 0, 1, 1, 0); drive(1, 0, 1, 1, 1);
    step(); idle();
    chk("R5", "ctr0 preset", cnt_of(0), 32'hA5A5_0001);
    chk("R6", "ctr1 preset via address 0x1", cnt_of(1), 32'h11);
    chk("R9", "ctr2 untouched", cnt_of(2), 32'd0);

    // R3 / R7: increment counter 2 onto match1=2, then hold
    tag = "R3";
    mode_load = 0; mode_shift = 0;
    drive(2, 0, 1, 1, 1); step();
    chk("R3", "ctr2 after one up", cnt_of(2), 32'd1);
    step();
    chk("R7", "ctr2 match1 pulse", W'(match1[2]), 1);
    drive(2, 0, 1, 0, 1); step();
    chk("R3", "ctr2 hold without qualifier", cnt_of(2), 32'd2);
    chk("R7", "ctr2 match1 single cycle", W'(match1[2]), 0);
    drive(2, 0, 1, 1, 1); repeat (3) step();
    chk("R7", "ctr2 match2 at 5", W'(match2[2]), 1);
    idle();

    // R2 / R7: clear drops counter 0 onto match words of zero
    tag = "R2";
    drive(0, 1, 0, 0, 0); step(); idle();
    chk("R2", "ctr0 cleared", cnt_of(0), 32'd0);
    chk("R7", "ctr0 match1 on clear", W'(match1[0]), 1);
    tag = "R3";
    drive(0, 0, 1, 1, 0); step(); idle();
    chk("R3", "ctr0 wrap down", cnt_of(0), 32'hFFFF_FFFF);

    // R2: clear beats a qualified event
    tag = "R2";
    drive(1, 1, 1, 1, 1); step(); idle();
    chk("R2", "ctr1 clear priority", cnt_of(1), 32'd0);

    // R4: shift in 1,0,1
    tag = "R4";
    mode_shift = 3'b010;
    drive(1, 0, 1, 1, 1); step();
    drive(1, 0, 1, 1, 0); step();
    drive(1, 0, 1, 1, 1); step(); idle();
    chk("R4", "ctr1 shifted value", cnt_of(1), 32'd5);
    tag = "R5";
    mode_load = 3'b010;
    drive(1, 0, 1, 1, 0); step(); idle();
    chk("R5", "load beats shift", cnt_of(1), 32'h11);
    mode_load = 0; mode_shift = 0;

    // R8: read-back
    rd_sel = 1; #1;
    chk("R8", "rd_sel 1", rd_data, 32'h11);
    rd_sel = 3; #1;
    chk("R8", "rd_sel 3", rd_data, 32'd0);

    // R9: random traffic, reference compared every cycle
    tag = "R9";
    for (int k = 0; k < 4000; k++) begin
      if (k % 400 == 0) begin
        mode_shift = N'($urandom);
        mode_load  = N'($urandom) & N'($urandom);
      end
      for (int i = 0; i < N; i++)
        drive(i, ($urandom % 40) == 0, $urandom % 2, ($urandom % 4) != 0, $urandom % 2);
      cfg_we    = ($urandom % 8) == 0;
      cfg_addr  = 4'($urandom);
      cfg_wdata = ($urandom % 2) ? W'($urandom % 6) : W'(32'hFFFF_FFFF - ($urandom % 4));
      rd_sel    = 2'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule